// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block works out where a load or store goes in memory, and what the base register should hold once the access is done. It takes a base register value and an offset. The offset is either a zero-extended immediate or an index register value shifted left by a 5-bit amount. The offset is added to or subtracted from the base, and the indexing mode then decides two things: which value is sent to memory as the effective address, and whether the base register is updated.

Three indexing modes are supported:

- **Offset:** the sum is used as the address and the base is left alone.
- **Pre-indexed:** the sum is both the address and the new base.
- **Post-indexed:** the old base is the address and the sum becomes the new base. A post-indexed byte walk with an offset of one therefore steps the base forward by one on each access.

All arithmetic wraps modulo 2^32. The datapath is combinational. It is followed by an output register that is enabled by default through a parameter.

Top module: `lsu_addr_gen`

## Requirements
- R1: With mode code 0 (offset), `ea_o` equals base plus or minus the offset, `base_wb_o` equals the unchanged base, and `wb_en_o` is 0.
- R2: With mode code 1 (pre-indexed), `ea_o` and `base_wb_o` both equal base plus or minus the offset, and `wb_en_o` is 1.
- R3: With mode code 2 (post-indexed), `ea_o` equals the unchanged base, `base_wb_o` equals base plus or minus the offset, and `wb_en_o` is 1.
- R4: Offset source selection:
  - When `use_index_i` is 0, the offset is `imm_i` zero-extended to 32 bits, and `index_i` and `shamt_i` have no effect.
  - When `use_index_i` is 1, the offset is `index_i` shifted left by `shamt_i`.
- R5: Index bits shifted beyond bit 31 are discarded.
- R6: `sub_i`=1 subtracts the offset and `sub_i`=0 adds it. Results wrap modulo 2^32 with no overflow indication.
- R7: Mode code 3 behaves exactly like offset mode: no writeback, and `base_wb_o` equals the base.
- R8: With the default output register, results appear one clock after the inputs are presented. All outputs are 0 while in reset. Reset is asynchronous active-low and is released through a two-stage synchronizer.
- R9: Feeding `base_wb_o` back as the base in post-indexed mode with an immediate offset of 1 produces effective addresses that step by one on each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Immediate offset, zero-extended |
| index_i | input | 32 | Index register value |
| shamt_i | input | 5 | Left-shift amount applied to the index |
| use_index_i | input | 1 | 1 selects the shifted index, 0 selects the immediate |
| sub_i | input | 1 | 1 subtracts the offset, 0 adds it |
| mode_i | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 offset |
| ea_o | output | 32 | Effective address |
| base_wb_o | output | 32 | Base value after the access |
| wb_en_o | output | 1 | Base writeback enable |

## Verification
The same base and offset are run through every mode. This separates which of the old base and the sum goes to memory, and which goes back to the base register. Immediate and shifted-index offsets are tried with junk on the unused source. This shows the source select really isolates the unused input. Shift amounts of 0, 2, 4 and 31 show that the shift counts correctly and discards high bits. Additions and subtractions that cross zero in either direction expose any attempt at saturation or an overflow leak. A short post-indexed walk feeds the writeback value back in and confirms the base steps by one per access.

// File: rtl/lsu_agu_pkg.sv
package lsu_agu_pkg;

  typedef enum logic [1:0] {
    IDX_OFFSET = 2'd0,
    IDX_PRE    = 2'd1,
    IDX_POST   = 2'd2,
    IDX_RSVD   = 2'd3
  } idx_mode_e;

  function automatic logic mode_writes_base(idx_mode_e m);
    return (m == IDX_PRE) || (m == IDX_POST);
  endfunction

endpackage

// File: rtl/agu_offset_sel.sv
module agu_offset_sel #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = 5
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic              use_index_i,
  output logic [ADDR_W-1:0] off_o
);
  localparam int PAD_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] imm_ext;
  logic [ADDR_W-1:0] idx_shl;

  // zero-extend immediate
  assign imm_ext = {{PAD_W{1'b0}}, imm_i};

  // bits leaving the top are dropped by the fixed result width
  always_comb begin
    idx_shl = index_i << shamt_i;
  end

  always_comb begin
    if (use_index_i) off_o = idx_shl;
    else             off_o = imm_ext;
  end
endmodule

// File: rtl/agu_addsub.sv
module agu_addsub #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic              sub_i,
  output logic [ADDR_W-1:0] sum_o
);
  // modulo arithmetic: carry/borrow out intentionally not kept
  always_comb begin
    if (sub_i) sum_o = base_i - off_i;
    else       sum_o = base_i + off_i;
  end
endmodule

// File: rtl/agu_mode_mux.sv
module agu_mode_mux
  import lsu_agu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] sum_i,
  input  idx_mode_e         mode_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] wb_o,
  output logic              wb_en_o
);
  always_comb begin
    wb_en_o = mode_writes_base(mode_i);
    unique case (mode_i)
      IDX_PRE: begin
        ea_o = sum_i;
        wb_o = sum_i;
      end
      IDX_POST: begin
        ea_o = base_i;
        wb_o = sum_i;
      end
      default: begin
        ea_o = sum_i;
        wb_o = base_i;
      end
    endcase
  end
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_agu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 12,
  parameter int SH_W    = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic              use_index_i,
  input  logic              sub_i,
  input  logic [1:0]        mode_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] base_wb_o,
  output logic              wb_en_o
);
  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  idx_mode_e         mode_e;
  logic [ADDR_W-1:0] off_w;
  logic [ADDR_W-1:0] sum_w;
  logic [ADDR_W-1:0] ea_d;
  logic [ADDR_W-1:0] wb_d;
  logic              wb_en_d;

  assign mode_e = idx_mode_e'(mode_i);

  agu_offset_sel #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_off (
    .imm_i       (imm_i),
    .index_i     (index_i),
    .shamt_i     (shamt_i),
    .use_index_i (use_index_i),
    .off_o       (off_w)
  );

  agu_addsub #(.ADDR_W(ADDR_W)) u_add (
    .base_i (base_i),
    .off_i  (off_w),
    .sub_i  (sub_i),
    .sum_o  (sum_w)
  );

  agu_mode_mux #(.ADDR_W(ADDR_W)) u_mux (
    .base_i  (base_i),
    .sum_i   (sum_w),
    .mode_i  (mode_e),
    .ea_o    (ea_d),
    .wb_o    (wb_d),
    .wb_en_o (wb_en_d)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [ADDR_W-1:0] ea_q;
      logic [ADDR_W-1:0] wb_q;
      logic              wb_en_q;
      logic              primed_q;

      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
          ea_q     <= '0;
          wb_q     <= '0;
          wb_en_q  <= 1'b0;
          primed_q <= 1'b0;
        end else begin
          ea_q     <= ea_d;
          wb_q     <= wb_d;
          wb_en_q  <= wb_en_d;
          primed_q <= 1'b1;
        end
      end

      assign ea_o      = ea_q;
      assign base_wb_o = wb_q;
      assign wb_en_o   = wb_en_q;

      // R1 R7
      offset_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (primed_q && ($past(mode_i) == 2'd0 || $past(mode_i) == 2'd3))
          |-> (!wb_en_o && base_wb_o == $past(base_i)));

      // R2
      pre_same_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (primed_q && $past(mode_i) == 2'd1) |-> (wb_en_o && ea_o == base_wb_o));

      // R3
      post_base_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (primed_q && $past(mode_i) == 2'd2) |-> (wb_en_o && ea_o == $past(base_i)));

      // R6
      addsub_inverse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (primed_q && $past(mode_i) == 2'd1)
          |-> (($past(sub_i) ? (ea_o + $past(off_w)) : (ea_o - $past(off_w)))
               == $past(base_i)));

      // R4
      imm_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (primed_q && $past(mode_i) == 2'd1 && !$past(use_index_i) && !$past(sub_i))
          |-> ((ea_o - $past(base_i)) < (ADDR_W'(1) << IMM_W)));
    end else begin : g_comb
      assign ea_o      = ea_d;
      assign base_wb_o = wb_d;
      assign wb_en_o   = wb_en_d;
    end
  endgenerate
endmodule

// File: tb/lsu_addr_gen_bench.sv
module lsu_addr_gen_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] base_i;
  logic [11:0] imm_i;
  logic [31:0] index_i;
  logic [4:0]  shamt_i;
  logic        use_index_i;
  logic        sub_i;
  logic [1:0]  mode_i;
  logic [31:0] ea_o;
  logic [31:0] base_wb_o;
  logic        wb_en_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  lsu_addr_gen u_lsu_addr_gen (
    .clk(clk), .rst_n(rst_n), .base_i(base_i), .imm_i(imm_i),
    .index_i(index_i), .shamt_i(shamt_i), .use_index_i(use_index_i),
    .sub_i(sub_i), .mode_i(mode_i), .ea_o(ea_o), .base_wb_o(base_wb_o),
    .wb_en_o(wb_en_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [31:0] base;
    logic [11:0] imm;
    logic [31:0] idx;
    logic [4:0]  sh;
    logic        use_idx;
    logic        sub;
    logic [1:0]  mode;
    logic [31:0] ea;
    logic [31:0] wb;
    logic        en;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R1 offset, immediate add
    '{32'h0000_1000, 12'h008, 32'h0, 5'd0, 1'b0, 1'b0, 2'd0, 32'h0000_1008, 32'h0000_1000, 1'b0},
    // R1 offset, immediate subtract
    '{32'h0000_1000, 12'h010, 32'h0, 5'd0, 1'b0, 1'b1, 2'd0, 32'h0000_0FF0, 32'h0000_1000, 1'b0},
    // R2 pre-indexed, immediate add
    '{32'h2000_0000, 12'h004, 32'h0, 5'd0, 1'b0, 1'b0, 2'd1, 32'h2000_0004, 32'h2000_0004, 1'b1},
    // R3 post-indexed, immediate 1
    '{32'h0000_0100, 12'h001, 32'h0, 5'd0, 1'b0, 1'b0, 2'd2, 32'h0000_0100, 32'h0000_0101, 1'b1},
    // R4 offset, index shifted by 2
    '{32'h0000_4000, 12'hABC, 32'h3, 5'd2, 1'b1, 1'b0, 2'd0, 32'h0000_400C, 32'h0000_4000, 1'b0},
    // R2 pre-indexed, index shifted by 4, subtract
    '{32'h0000_1000, 12'h000, 32'h10, 5'd4, 1'b1, 1'b1, 2'd1, 32'h0000_0F00, 32'h0000_0F00, 1'b1},
    // R3 R6 post-indexed, unshifted index, subtract below zero
    '{32'h0000_0080, 12'h000, 32'h90, 5'd0, 1'b1, 1'b1, 2'd2, 32'h0000_0080, 32'hFFFF_FFF0, 1'b1},
    // R5 shift by 31 drops high bits
    '{32'h0000_0001, 12'h000, 32'h8000_0003, 5'd31, 1'b1, 1'b0, 2'd0, 32'h8000_0001, 32'h0000_0001, 1'b0},
    // R6 pre-indexed add wraps past the top
    '{32'hFFFF_FFFC, 12'h008, 32'h0, 5'd0, 1'b0, 1'b0, 2'd1, 32'h0000_0004, 32'h0000_0004, 1'b1},
    // R7 mode 3 acts as offset mode
    '{32'h0000_0500, 12'h020, 32'h0, 5'd0, 1'b0, 1'b0, 2'd3, 32'h0000_0520, 32'h0000_0500, 1'b0},
    // R4 immediate selected, index and shift junk ignored
    '{32'h0000_0000, 12'h0FF, 32'h0000_FFFF, 5'd5, 1'b0, 1'b0, 2'd0, 32'h0000_00FF, 32'h0000_0000, 1'b0},
    // R4 largest immediate is zero-extended
    '{32'h0001_0000, 12'hFFF, 32'h0, 5'd0, 1'b0, 1'b1, 2'd1, 32'h0000_F001, 32'h0000_F001, 1'b1}
  };

  task automatic chk32(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    base_i      = v.base;
    imm_i       = v.imm;
    index_i     = v.idx;
    shamt_i     = v.sh;
    use_index_i = v.use_idx;
    sub_i       = v.sub;
    mode_i      = v.mode;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(VECS[0]);

    // R8: outputs held at zero during reset, even with live inputs
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk32("R8", "reset ea", ea_o, 32'h0);
    chk32("R8", "reset wb", base_wb_o, 32'h0);
    chk32("R8", "reset en", {31'b0, wb_en_o}, 32'h0);

    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: drive at a falling edge, check after the next rising edge
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(posedge clk);
      #1;
      chk32("R1-7 vec", $sformatf("ea[%0d]", i), ea_o, VECS[i].ea);
      chk32("R1-7 vec", $sformatf("wb[%0d]", i), base_wb_o, VECS[i].wb);
      chk32("R1-7 vec", $sformatf("en[%0d]", i), {31'b0, wb_en_o}, {31'b0, VECS[i].en});
    end

    // R8: one clock of latency, so the output has not changed before the edge
    @(negedge clk);
    base_i = 32'h0000_7000; imm_i = 12'h0; use_index_i = 1'b0;
    sub_i = 1'b0; mode_i = 2'd0;
    #1;
    chk32("R8", "latency hold", ea_o, VECS[NV-1].ea);
    @(posedge clk); #1;
    chk32("R8", "latency update", ea_o, 32'h0000_7000);

    // R9: post-indexed walk, feeding the written-back base in again
    begin
      logic [31:0] b;
      b = 32'h2000_0040;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        base_i = b; imm_i = 12'h001; use_index_i = 1'b0;
        sub_i = 1'b0; mode_i = 2'd2;
        @(posedge clk); #1;
        chk32("R9", $sformatf("walk ea[%0d]", k), ea_o, 32'h2000_0040 + k);
        chk32("R9", $sformatf("walk wb[%0d]", k), base_wb_o, 32'h2000_0041 + k);
        b = base_wb_o;
      end
    end

    // R8: asynchronous reset mid-run clears the outputs before any edge
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk32("R8", "async clear ea", ea_o, 32'h0);
    chk32("R8", "async clear en", {31'b0, wb_en_o}, 32'h0);
    rst_n = 1'b1;

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule